// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device end of a three-wire serial memory link. A host drives chip select, a serial clock and a serial data line. The block waits for a start bit, then shifts in a two-bit opcode, a six-bit word address and, for a write, a sixteen-bit data word. Reads, writes and erases all act on a 64 x 16 register array. The serial clock and data are synchronized into the system clock domain, and rising serial-clock edges are detected there.

Writes and erases launch a self-timed programming cycle. A counter on the system clock times this cycle, so it needs no serial clock edges. Once a cycle has started it always runs to the end, even if chip select falls partway through. The data-out line is modelled as a value plus an output enable. When chip select is raised again after programming has begun, the line reports busy or ready. Otherwise it stays released except while read data is being shifted out.

Top module: `tw_eeprom_slave`

## Requirements
- R1: While chip select is low, the command sequencer is held idle and clock edges and data are ignored. A frame cut short by a low chip select is abandoned, and a later complete frame runs normally.
- R2: With chip select high, rising clock edges that sample data at 0 before a start bit change nothing. The first edge that samples 1 is the start bit.
- R3: After the start bit come two opcode bits (10 read, 01 write, 11 erase, 00 special), then six address bits, most significant first. A write frame adds 16 data bits, most significant first. The command executes on the edge that samples the last bit of its frame.
- R4: On a read, data-out is enabled with a dummy 0 after the last address edge. Each of the next 16 rising edges then puts out one bit of the word, MSB first. The line is released on the 17th edge.
- R5: A write or erase commits its word to the array only after PROG_CYCLES system clocks. It completes even if chip select drops during it.
- R6: An erase sets the addressed word to 16'hFFFF.
- R7: A special frame with address bits [5:4] = 11 enables programming, and one with [5:4] = 00 disables it. Programming is disabled after reset, and writes and erases arriving while it is disabled change nothing.
- R8: After a write or erase has started, chip select falls and rises again. Data-out is then driven: 0 while programming runs and 1 once it has finished. This lasts until the next start bit.
- R9: Data-out stays released throughout reset and whenever chip select is low. After a start bit and a chip select drop, the busy/ready indication is gone and data-out stays released when chip select is raised.
- R10: Once a frame is complete, further clock edges and data are ignored until chip select goes low.
- R11: Write, erase and special frames that arrive while a programming cycle is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, high selects |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data / status value |
| sdo_en | output | 1 | Output enable of the data-out driver |

## Verification
The bench targets the corners where a wrong sequencer would go astray. It sends leading zeros before the start bit; a design that treated any edge as a start would decode a shifted opcode. It drops chip select mid-frame; a design that kept partial state would then mis-decode the following read. It keeps clocking ones after a finished frame; a design that re-armed on them would start a stray read and enable data-out. It holds chip select low through a whole programming cycle, sends a write while busy and sends a write while programming is disabled. A design that aborted, accepted or leaked those would show the wrong word on readback or drive data-out when it should not.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } tw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_WDATA = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } tw_state_e;

  // Sub-codes carried in the top two address bits of a special frame
  localparam logic [1:0] SUB_ENABLE  = 2'b11;
  localparam logic [1:0] SUB_DISABLE = 2'b00;

  // Opcode plus address bits following the start bit
  function automatic int hdr_bits(input int aw);
    return aw + 2;
  endfunction

  // Counter width able to hold the longer of header and data length
  function automatic int cnt_width(input int hl, input int dw);
    int m;
    m = (hl > dw) ? hl : dw;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CW'(CYCLES);
    else if (remain != '0)   remain <= remain - CW'(1);
  end

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5

endmodule

// File: rtl/tw_word_array.sv
module tw_word_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         words[g] <= '0;
      else if (we && waddr == AW'(g))     words[g] <= wdata;
    end
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);

  localparam int HL = hdr_bits(ADDR_W);
  localparam int CW = cnt_width(HL, DATA_W);

  // ---------------- input synchronization ----------------
  logic [2:0] raw_in, sync_q;
  logic       cs_s, sclk_s, sdi_s, sclk_q, bit_rise;

  assign raw_in = {cs, sclk, sdi};

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_q)
  );

  assign cs_s   = sync_q[2];
  assign sclk_s = sync_q[1];
  assign sdi_s  = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign bit_rise = cs_s & sclk_s & ~sclk_q;

  // ---------------- named events ----------------
  tw_state_e         st;
  logic [CW-1:0]     cnt;
  logic [HL-1:0]     hdr, hdr_n;
  logic [DATA_W-1:0] wdat, wdat_n, rd_word, mem_rdata, pend_data;
  logic [ADDR_W-1:0] hdr_addr, pend_addr;
  tw_op_e            op_n;
  logic hdr_last, wdat_last, start_seen, prog_req, prog_start;
  logic busy, prog_done, wen_q, stat_arm, sdo_q, sdo_en_q;

  always_comb begin
    hdr_n      = {hdr[HL-2:0], sdi_s};
    wdat_n     = {wdat[DATA_W-2:0], sdi_s};
    op_n       = tw_op_e'(hdr_n[HL-1 -: 2]);
    hdr_addr   = hdr_n[ADDR_W-1:0];
    hdr_last   = bit_rise && (st == ST_HDR)   && (cnt == CW'(HL-1));
    wdat_last  = bit_rise && (st == ST_WDATA) && (cnt == CW'(DATA_W-1));
    start_seen = bit_rise && (st == ST_IDLE)  && sdi_s;
    prog_req   = wdat_last || (hdr_last && op_n == OP_ERASE);
    prog_start = prog_req && wen_q && !busy;
  end

  // ---------------- storage and timer ----------------
  tw_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (prog_done),
    .waddr (pend_addr),
    .wdata (pend_data),
    .raddr (hdr_addr),
    .rdata (mem_rdata)
  );

  tw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_start),
    .busy  (busy),
    .done  (prog_done)
  );

  // ---------------- command sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      hdr     <= '0;
      wdat    <= '0;
      rd_word <= '0;
    end else if (!cs_s) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (bit_rise) begin
      case (st)
        ST_IDLE: begin
          if (sdi_s) begin
            st  <= ST_HDR;
            cnt <= '0;
          end
        end
        ST_HDR: begin
          hdr <= hdr_n;
          cnt <= cnt + CW'(1);
          if (hdr_last) begin
            cnt <= '0;
            case (op_n)
              OP_READ: begin
                st      <= ST_READ;
                rd_word <= mem_rdata;
              end
              OP_WRITE: st <= ST_WDATA;
              default:  st <= ST_DONE;
            endcase
          end
        end
        ST_WDATA: begin
          wdat <= wdat_n;
          cnt  <= cnt + CW'(1);
          if (wdat_last) st <= ST_DONE;
        end
        ST_READ: begin
          cnt     <= cnt + CW'(1);
          rd_word <= {rd_word[DATA_W-2:0], 1'b0};
          if (cnt == CW'(DATA_W)) st <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  // ---------------- enable latch, pending word, status arm ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q     <= 1'b0;
      stat_arm  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      if (hdr_last && op_n == OP_SPECIAL && !busy) begin
        if (hdr_addr[ADDR_W-1 -: 2] == SUB_ENABLE)       wen_q <= 1'b1;
        else if (hdr_addr[ADDR_W-1 -: 2] == SUB_DISABLE) wen_q <= 1'b0;
      end
      if (prog_start) begin
        pend_addr <= wdat_last ? hdr[ADDR_W-1:0] : hdr_addr;
        pend_data <= wdat_last ? wdat_n : '1;
      end
      if (prog_start)      stat_arm <= 1'b1;
      else if (start_seen) stat_arm <= 1'b0;
    end
  end

  // ---------------- data-out driver ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q    <= 1'b0;
      sdo_en_q <= 1'b0;
    end else if (!cs_s) begin
      sdo_en_q <= 1'b0;
    end else if (hdr_last && op_n == OP_READ) begin
      sdo_en_q <= 1'b1;
      sdo_q    <= 1'b0;
    end else if (st == ST_READ) begin
      if (bit_rise) begin
        if (cnt == CW'(DATA_W)) sdo_en_q <= 1'b0;
        else                    sdo_q    <= rd_word[DATA_W-1];
      end
    end else if (st == ST_IDLE && stat_arm && !start_seen) begin
      sdo_en_q <= 1'b1;
      sdo_q    <= !busy;
    end else begin
      sdo_en_q <= 1'b0;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_en = sdo_en_q;

  AST_DESELECT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (st == ST_IDLE)); // R1
  AST_SDO_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdo_en); // R9
  AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q)); // R7
  AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_last && op_n == OP_READ) |=> (sdo_en && !sdo)); // R4

endmodule

// File: tb/test_tw_eeprom_slave.sv
module test_tw_eeprom_slave;

  localparam int PROG = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [15:0] model [64];

  always #2 clk = ~clk;

  tw_eeprom_slave #(.PROG_CYCLES(PROG)) i_tw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic e, output logic v);
    sdi = b; tick(4);
    sclk = 1'b1; tick(8);
    e = sdo_en; v = sdo;
    sclk = 1'b0; tick(4);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
    logic e, v;
    clk_bit(1'b1, e, v);
    for (int i = 1; i >= 0; i--) clk_bit(op[i], e, v);
    for (int i = 5; i >= 0; i--) clk_bit(a[i], e, v);
  endtask

  task automatic cs_lo(); cs = 1'b0; tick(8); endtask
  task automatic cs_hi(); cs = 1'b1; tick(8); endtask

  task automatic send_word(input logic [15:0] d);
    logic e, v;
    for (int i = 15; i >= 0; i--) clk_bit(d[i], e, v);
  endtask

  task automatic rd(input logic [5:0] a, input int zeros, output logic [15:0] w,
                    output logic dummy_ok, output logic all_en, output logic tail_hiz);
    logic e, v;
    cs_hi();
    for (int i = 0; i < zeros; i++) clk_bit(1'b0, e, v);
    send_hdr(2'b10, a);
    dummy_ok = sdo_en && !sdo;
    all_en = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, e, v);
      w[i] = v;
      all_en = all_en & e;
    end
    clk_bit(1'b0, e, v);
    tail_hiz = !e;
    cs_lo();
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input int zeros);
    logic [15:0] w;
    logic d, ae, th;
    rd(a, zeros, w, d, ae, th);
    chk(tag, {16'h0, w}, {16'h0, model[a]});
    chk({tag, " dummy/enable"}, {29'h0, d, ae, th}, 32'h7);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    cs_hi(); send_hdr(2'b01, a); send_word(d); cs_lo();
  endtask

  task automatic er(input logic [5:0] a);
    cs_hi(); send_hdr(2'b11, a); cs_lo();
  endtask

  task automatic special(input logic [5:0] a);
    cs_hi(); send_hdr(2'b00, a); cs_lo();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic e, v;
    for (int i = 0; i < 64; i++) model[i] = 16'h0;
    tick(5);
    chk("R9 reset hi-z", {31'h0, sdo_en}, 32'h0);
    rst_n = 1'b1; tick(5);
    chk("R9 after reset hi-z", {31'h0, sdo_en}, 32'h0);

    // R3 R4: basic read of reset contents
    rd_chk("R4 read reset word", 6'd5, 0);

    // R7: write while disabled is dropped
    wr(6'd3, 16'hBEEF);
    cs_hi();
    chk("R7 no status without prog", {31'h0, sdo_en}, 32'h0);
    cs_lo();
    tick(PROG + 30);
    rd_chk("R7 disabled write ignored", 6'd3, 0);

    // R7 enable, R8 busy then ready
    special(6'b110000);
    wr(6'd3, 16'hA5C3);
    model[3] = 16'hA5C3;
    cs_hi();
    chk("R8 busy shown", {30'h0, sdo_en, sdo}, 32'h2);
    tick(PROG);
    chk("R8 ready shown", {30'h0, sdo_en, sdo}, 32'h3);
    // R9: start bit then CS low clears status
    clk_bit(1'b1, e, v);
    cs_lo(); cs_hi();
    chk("R9 status cleared by start", {31'h0, sdo_en}, 32'h0);
    cs_lo();
    rd_chk("R5 write committed", 6'd3, 0);

    // R5 R9: CS low throughout programming
    wr(6'd7, 16'h1234);
    model[7] = 16'h1234;
    for (int k = 0; k < 3; k++) begin
      tick(200);
      chk("R9 hi-z while CS low busy", {31'h0, sdo_en}, 32'h0);
    end
    tick(PROG);
    rd_chk("R5 completes with CS low", 6'd7, 0);

    // R11: write while busy ignored
    wr(6'd9, 16'h1111);
    model[9] = 16'h1111;
    wr(6'd10, 16'h2222);
    special(6'b000000);
    tick(PROG + 30);
    rd_chk("R11 busy write ignored", 6'd10, 0);
    rd_chk("R11 first write kept", 6'd9, 0);
    wr(6'd11, 16'h3333);
    model[11] = 16'h3333;
    tick(PROG + 30);
    rd_chk("R11 disable while busy ignored", 6'd11, 0);

    // R6: erase
    er(6'd3);
    model[3] = 16'hFFFF;
    tick(PROG + 30);
    rd_chk("R6 erase all ones", 6'd3, 0);

    // R1: abandoned partial frame
    cs_hi();
    clk_bit(1'b1, e, v); clk_bit(1'b1, e, v); clk_bit(1'b0, e, v);
    cs_lo();
    cs = 1'b0;
    clk_bit(1'b1, e, v); clk_bit(1'b1, e, v);
    chk("R1 deselected clocks ignored", {31'h0, sdo_en}, 32'h0);
    rd_chk("R1 read after abandoned frame", 6'd7, 0);

    // R2: leading zeros
    rd_chk("R2 leading zeros", 6'd9, 5);

    // R10: extra clocks after complete frame
    cs_hi(); send_hdr(2'b01, 6'd12); send_word(16'h5A5A);
    model[12] = 16'h5A5A;
    begin
      logic any_en;
      any_en = 1'b0;
      for (int i = 0; i < 12; i++) begin
        clk_bit(1'b1, e, v);
        any_en = any_en | e;
      end
      chk("R10 trailing clocks ignored", {31'h0, any_en}, 32'h0);
    end
    cs_lo();
    tick(PROG + 30);
    rd_chk("R10 word intact", 6'd12, 0);

    // R7: disable then write dropped
    special(6'b001111);
    wr(6'd3, 16'h0F0F);
    tick(PROG + 30);
    rd_chk("R7 disabled again", 6'd3, 0);

    // Random mix, fixed seed
    special(6'b111010);
    void'($urandom(32'h5eed));
    for (int it = 0; it < 24; it++) begin
      logic [5:0]  a;
      logic [15:0] d;
      int kind;
      a    = 6'($urandom % 64);
      d    = 16'($urandom);
      kind = int'($urandom % 3);
      if (kind == 0) begin
        wr(a, d); model[a] = d; tick(PROG + 30);
        rd_chk("R3 random write/read", a, int'($urandom % 3));
      end else if (kind == 1) begin
        er(a); model[a] = 16'hFFFF; tick(PROG + 30);
        rd_chk("R6 random erase/read", a, 0);
      end else begin
        rd_chk("R4 random read", a, int'($urandom % 4));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule